// File: doc/BRIEF.md
# Parallel Counter-Mode Cell Combiner

The block applies counter-mode keystream to 48-byte cell payloads. One cell arrives as a single 384-bit word. It is split into three 128-bit slices, and each slice is served by its own cipher lane. Slice k takes the keystream produced from the running counter plus k. The combined cell leaves in the same slice order it arrived in. XOR with keystream is its own inverse, so the same path both encrypts and decrypts.

Each lane talks to an external cipher engine through a request/response pair. The lane raises a request carrying its counter value and holds it until the engine returns one acknowledge pulse with the keystream. Requests do not depend on payload data, so lanes fetch keystream ahead of the next cell. The lanes may finish in any order. After each cell the running counter moves on by three. The output stream is therefore the same as that of one engine stepping through the counter sequence one block at a time.

Top module: `pcx_cell_xor`

## Requirements
- R1: Output slice k (bits k*128 upward, k = 0..2) equals input slice k XOR the keystream the engine returned for counter value base+k, where base is the running counter.
- R2: Each delivered cell advances the running counter by 3, so consecutive cells use consecutive counter values with no gap or reuse.
- R3: Passing an output cell back through the block from the same initial counter restores the original cell.
- R4: Lanes raise their requests, with counter values base+0, base+1 and base+2, without waiting for payload. Once keystream is prefetched, an accepted cell is presented on the output in the next cycle.
- R5: out_valid rises only after all three lanes have returned keystream for the cell, whatever order the acknowledges arrive in.
- R6: While out_valid is high and out_ready low, out_valid stays high and out_cell does not change.
- R7: Counter arithmetic is modulo 2^128. wrap_flag goes high and stays high once an advance carries past 2^128-1, and it is cleared by reset or by a counter load.
- R8: A load (ld_en) sets the running counter to ld_ctr only when no cell is held and no lane request is outstanding. At any other time it is ignored.
- R9: After reset, out_valid is 0, in_ready is 1, wrap_flag is 0 and the running counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load strobe for the running counter |
| ld_ctr | input | 128 | New initial counter value |
| in_valid | input | 1 | Input cell valid |
| in_ready | output | 1 | Block can take a cell |
| in_cell | input | 384 | Input cell, slice k at bits [k*128 +: 128] |
| ks_req | output | 3 | Per-lane keystream request, held until acknowledged |
| ks_ctr | output | 384 | Per-lane counter value, lane k at bits [k*128 +: 128] |
| ks_ack | input | 3 | Per-lane one-cycle response strobe |
| ks_data | input | 384 | Per-lane keystream, lane k at bits [k*128 +: 128] |
| out_valid | output | 1 | Output cell valid |
| out_ready | input | 1 | Downstream accepts the output cell |
| out_cell | output | 384 | Processed cell in input slice order |
| wrap_flag | output | 1 | Sticky counter wrap indicator |

## Verification
The assertions assume that the cipher engines acknowledge only a request that is currently raised, with exactly one pulse per request, and that in_cell is stable while in_valid waits for in_ready. The bench's responders watch ks_req and pulse ks_ack for one cycle after a lane-dependent, changing delay, so acknowledges come back in varied orders. Loads are issued only after the bench has seen the block go idle at its ports, except for one load that is placed deliberately while a cell is held, to show that it is ignored.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  localparam int BLK_W = 128;
  typedef logic [BLK_W-1:0] blk_t;

  // counter plus offset, carry in the top bit
  function automatic logic [BLK_W:0] ctr_add(blk_t base, int unsigned off);
    return {1'b0, base} + (BLK_W+1)'(off);
  endfunction

  function automatic blk_t mix_slice(blk_t data, blk_t ks);
    return data ^ ks;
  endfunction
endpackage

// File: rtl/pcx_ctr_base.sv
module pcx_ctr_base
  import pcx_pkg::*;
#(
  parameter int STEP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_fire,
  input  blk_t ld_val,
  input  logic adv,
  output blk_t base,
  output logic wrap
);
  logic [BLK_W:0] nxt;
  assign nxt = ctr_add(base, STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
      wrap <= 1'b0;
    end else if (ld_fire) begin
      base <= ld_val;
      wrap <= 1'b0;
    end else if (adv) begin
      base <= nxt[BLK_W-1:0];
      if (nxt[BLK_W]) wrap <= 1'b1;
    end
  end

  // R2: each advance moves the counter on by STEP, modulo 2^128
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !ld_fire |=> base == $past(base) + BLK_W'(STEP));
  // R7: wrap flag is sticky until a load
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wrap && !ld_fire |=> wrap);
  // R7: a carrying advance raises the flag
  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !ld_fire && ($countones(base) == BLK_W) |=> wrap);
endmodule

// File: rtl/pcx_lane.sv
module pcx_lane
  import pcx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  blk_t ctr,
  input  logic go,
  input  logic clr,
  output logic req,
  output blk_t req_ctr,
  input  logic ack,
  input  blk_t ks_in,
  output logic have,
  output blk_t ks
);
  logic pend;
  logic got;

  assign req     = pend;
  assign req_ctr = ctr;
  assign got     = pend && ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      have <= 1'b0;
      ks   <= '0;
    end else if (clr) begin
      have <= 1'b0;
    end else if (got) begin
      pend <= 1'b0;
      have <= 1'b1;
      ks   <= ks_in;
    end else if (!pend && !have && go) begin
      pend <= 1'b1;
    end
  end

  // R4: a raised request and its counter hold until acknowledged
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> req && $stable(req_ctr));
  // R5: keystream only becomes available through an acknowledge
  a_r5_have_src: assert property (@(posedge clk) disable iff (!rst_n)
    !have && !got |=> !have);
endmodule

// File: rtl/pcx_cell_xor.sv
module pcx_cell_xor
  import pcx_pkg::*;
#(
  parameter int LANES = 3,
  localparam int CELL_W = BLK_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [BLK_W-1:0]  ld_ctr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CELL_W-1:0] in_cell,
  output logic [LANES-1:0]  ks_req,
  output logic [CELL_W-1:0] ks_ctr,
  input  logic [LANES-1:0]  ks_ack,
  input  logic [CELL_W-1:0] ks_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CELL_W-1:0] out_cell,
  output logic              wrap_flag
);
  logic              held;
  logic [CELL_W-1:0] cell_q;
  logic [LANES-1:0]  have_v;
  blk_t              base;
  logic              busy, ld_fire, in_fire, out_fire;

  assign busy      = held || (|ks_req);
  assign ld_fire   = ld_en && !busy;
  assign in_ready  = !held;
  assign in_fire   = in_valid && in_ready;
  assign out_valid = held && (&have_v);
  assign out_fire  = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held   <= 1'b0;
      cell_q <= '0;
    end else if (in_fire) begin
      held   <= 1'b1;
      cell_q <= in_cell;
    end else if (out_fire) begin
      held   <= 1'b0;
    end
  end

  pcx_ctr_base #(.STEP(LANES)) u_base (
    .clk(clk), .rst_n(rst_n), .ld_fire(ld_fire), .ld_val(ld_ctr),
    .adv(out_fire), .base(base), .wrap(wrap_flag)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [BLK_W:0] sum;
    blk_t           ks_k;
    assign sum = ctr_add(base, k);

    pcx_lane u_lane (
      .clk(clk), .rst_n(rst_n), .ctr(sum[BLK_W-1:0]), .go(!ld_fire),
      .clr(out_fire || ld_fire), .req(ks_req[k]),
      .req_ctr(ks_ctr[k*BLK_W +: BLK_W]), .ack(ks_ack[k]),
      .ks_in(ks_data[k*BLK_W +: BLK_W]), .have(have_v[k]), .ks(ks_k)
    );

    assign out_cell[k*BLK_W +: BLK_W] = mix_slice(cell_q[k*BLK_W +: BLK_W], ks_k);
  end

  // R6: a stalled output keeps its valid and data
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_cell));
  // R8: a load while busy leaves the counter alone
  a_r8_ld_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && busy && !out_fire |=> $stable(base));
  // R5: no output while any lane still has a request open
  a_r5_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    |ks_req |-> !out_valid);
endmodule

// File: tb/tb_pcx_cell_xor.sv
module tb_pcx_cell_xor;
  import pcx_pkg::*;
  localparam int L = 3;
  localparam int CW = BLK_W * L;

  logic clk = 0, rst_n = 0;
  logic ld_en = 0;
  blk_t ld_ctr = '0;
  logic in_valid = 0;
  logic in_ready;
  logic [CW-1:0] in_cell = '0;
  logic [L-1:0] ks_req;
  logic [CW-1:0] ks_ctr;
  logic [L-1:0] ks_ack = '0;
  logic [CW-1:0] ks_data = '0;
  logic out_valid;
  logic out_ready = 1;
  logic [CW-1:0] out_cell;
  logic wrap_flag;

  int checks = 0, errors = 0;
  logic [CW-1:0] expq[$];
  logic [CW-1:0] last_out;
  blk_t mdl;
  int wcnt[L];
  int rcnt[L];
  bit hold_rdy = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pcx_cell_xor dut (.*);

  function automatic blk_t ciph(blk_t x);
    blk_t t;
    t = x ^ 128'h5a5a_0f0f_3c3c_a5a5_9696_c3c3_1e1e_7878;
    t = {t[90:0], t[127:91]};
    return t + 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3211;
  endfunction

  task automatic chk(bit ok, string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // stand-in cipher engines with changing per-lane delay
  always @(negedge clk) begin
    for (int l = 0; l < L; l++) begin
      if (ks_ack[l]) ks_ack[l] <= 1'b0;
      else if (rst_n && ks_req[l]) begin
        if (wcnt[l] >= (rcnt[l] + 2*l) % 5) begin
          ks_ack[l] <= 1'b1;
          ks_data[l*BLK_W +: BLK_W] <= ciph(ks_ctr[l*BLK_W +: BLK_W]);
          wcnt[l] <= 0;
          rcnt[l] <= rcnt[l] + 1;
        end else wcnt[l] <= wcnt[l] + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready <= hold_rdy ? 1'b0 : ((cyc % 3) != 1);
  end

  // monitor: R1, R2, R5 through scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      last_out = out_cell;
      if (expq.size() == 0) chk(0, "R5 unexpected output", out_cell, '0);
      else begin
        logic [CW-1:0] e;
        e = expq.pop_front();
        chk(out_cell == e, "R1/R2 cell content", out_cell, e);
      end
    end
  end

  task automatic send(logic [CW-1:0] d);
    logic [CW-1:0] e;
    for (int k = 0; k < L; k++)
      e[k*BLK_W +: BLK_W] = d[k*BLK_W +: BLK_W] ^ ciph(mdl + BLK_W'(k));
    expq.push_back(e);
    mdl = mdl + BLK_W'(L);
    @(negedge clk);
    in_valid = 1; in_cell = d;
    while (1) begin
      if (in_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_load(blk_t v);
    drain();
    while (!(in_ready && ks_req == '0 && !out_valid)) @(negedge clk);
    ld_en = 1; ld_ctr = v;
    @(negedge clk);
    ld_en = 0;
    mdl = v;
  endtask

  function automatic logic [CW-1:0] pat(int n);
    logic [CW-1:0] p;
    for (int k = 0; k < 12; k++) p[k*32 +: 32] = 32'h9e37_79b9 * (n*12 + k + 1);
    return p;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", '0, '0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [CW-1:0] p, c, snap;
    for (int l = 0; l < L; l++) begin wcnt[l] = 0; rcnt[l] = 0; end
    mdl = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R9 out_valid after reset", CW'(out_valid), '0);
    chk(in_ready == 1, "R9 in_ready after reset", CW'(in_ready), 1);
    chk(wrap_flag == 0, "R9 wrap_flag after reset", CW'(wrap_flag), '0);
    rst_n = 1;
    @(posedge clk); #1;
    chk(ks_req == 3'b111, "R4 prefetch requests", CW'(ks_req), CW'(3'b111));
    for (int k = 0; k < L; k++)
      chk(ks_ctr[k*BLK_W +: BLK_W] == BLK_W'(k), "R4/R9 lane counter from zero",
          CW'(ks_ctr[k*BLK_W +: BLK_W]), CW'(k));

    // R4: after prefetch, output valid the cycle after acceptance
    hold_rdy = 1;
    while (ks_req != '0) @(negedge clk);
    repeat (2) @(negedge clk);
    send(pat(0));
    chk(out_valid == 1, "R4 output right after accept", CW'(out_valid), 1);
    // R6: stalled output holds; R8: load while held is ignored
    snap = out_cell;
    ld_en = 1; ld_ctr = 128'hdead;
    @(negedge clk); ld_en = 0;
    repeat (4) @(negedge clk);
    chk(out_valid == 1, "R6 valid held", CW'(out_valid), 1);
    chk(out_cell == snap, "R6 data held", out_cell, snap);
    hold_rdy = 0;

    // R1/R2/R5/R8: several cells with varied data and lane timing
    for (int n = 1; n < 7; n++) send(pat(n));
    drain();

    // R3: round trip from the same initial counter
    do_load(128'h1234_5678_0000_0000_cafe_0000_0000_0001);
    p = pat(20);
    send(p);
    drain();
    c = last_out;
    do_load(128'h1234_5678_0000_0000_cafe_0000_0000_0001);
    send(c);
    drain();
    chk(last_out == p, "R3 decrypt restores cell", last_out, p);

    // R7: wrap across 2^128
    do_load({BLK_W{1'b1}} - 1);
    chk(wrap_flag == 0, "R7 no wrap before advance", CW'(wrap_flag), '0);
    send(pat(30));
    drain();
    chk(wrap_flag == 1, "R7 wrap raised", CW'(wrap_flag), 1);
    send(pat(31));
    drain();
    chk(wrap_flag == 1, "R7 wrap sticky", CW'(wrap_flag), 1);
    do_load(128'h5);
    @(negedge clk);
    chk(wrap_flag == 0, "R7 load clears wrap", CW'(wrap_flag), '0);
    send(pat(32));
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule